// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Unit

This block is the trigger sequencer of a 32-bit processor's debug logic. Software writes a 32-bit trigger definition word through a simple register port. The upper half holds the second-level condition and the two-bit response code. The lower half holds the first-level condition. Each level can match on three things. The first is an address compare: an exact low-address hit, an inside-range hit or an outside-range hit. The second is a data compare, qualified by access size and byte lane, with an optional inversion. The third is a program-counter compare, also with an optional inversion.

When only one level is enabled, that level alone completes the trigger. When both are enabled, the second level is armed only after the first has fired. A completed trigger is always reported on a one-cycle trace pulse. The response code can add a one-cycle halt request or a one-cycle debug interrupt. A two-bit status field shows the progress. Any register write returns the status to idle. Software should clear both level enables before it changes the comparison fields, because nothing blocks matches while a new definition is being loaded.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the register reads zero, status_o is 00, and trig_o, halt_o and dbg_irq_o are low.
- R2: Register bits 31:16 and 13:0 read back as written. Bits 15:14 always read zero.
- R3: A write sets status_o to 00 in the following cycle, and no response pulse follows that write.
- R4: When bit 29 (level-2 enable) and bit 13 (level-1 enable) are both clear, no trigger completes.
- R5: Each level has its own fields, at bits 13:0 for level 1 and bits 29:16 for level 2. Listed as level-1 bit positions, level 2 adding 16:
  - The address enables are bit 2 (address equals the low bound), bit 3 (lo <= address <= hi) and bit 4 (address outside that range). Each enabled mode that holds gives an address match.
  - With all three address enables clear, the address is not compared.
- R6: The data enables are:
  - bit 12: longword, size 2.
  - bit 10: upper word, size 1 with addr[1]=0, data[31:16].
  - bit 11: lower word, size 1 with addr[1]=1, data[15:0].
  - bits 9..6: bytes at address offsets 0..3, size 0, on lanes data[31:24] down to data[7:0].

  Only the qualified lanes are compared. With all seven data enables clear, data is not compared.
- R7: Bit 5 inverts the data compare result. A data access still has to qualify by size and lane.
- R8: Bit 1 enables the program-counter compare of pc_i against brk_pc_i. Bit 0 inverts the result.
- R9: A data access completes a level only when every enabled category (address and data) matches. A program-counter match completes the level on its own.
- R10: With both levels enabled:
  - A level-2 match while status_o is 00 is ignored.
  - A level-1 match moves status_o to 01 with no response pulse.
  - A following level-2 match moves status_o to 10 and fires the response.
- R11: With a single level enabled, a match of that level fires the response. status_o becomes 01 for level 1 and 10 for level 2.
- R12: On completion, trig_o pulses for one cycle. The response code in bits 31:30 adds a pulse as follows:
  - 01 adds a one-cycle halt_o pulse.
  - 10 adds a one-cycle dbg_irq_o pulse.
  - 00 and 11 add nothing.
- R13: After completion, further matches give no pulse and leave status_o unchanged until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Trigger register write strobe |
| reg_wdata_i | input | 32 | Trigger register write data |
| reg_rdata_o | output | 32 | Trigger register read data |
| acc_valid_i | input | 1 | Data access valid this cycle |
| acc_addr_i | input | ADDR_W | Data access address |
| acc_size_i | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| acc_data_i | input | 32 | Lane-aligned access data |
| pc_valid_i | input | 1 | Program counter valid this cycle |
| pc_i | input | ADDR_W | Program counter |
| brk_addr_lo_i | input | ADDR_W | Address low bound / exact address |
| brk_addr_hi_i | input | ADDR_W | Address high bound |
| brk_data_i | input | 32 | Data compare value |
| brk_pc_i | input | ADDR_W | Program counter compare value |
| status_o | output | 2 | 00 idle, 01 level-1 hit, 10 level-2 hit |
| trig_o | output | 1 | One-cycle completed-trigger trace pulse |
| halt_o | output | 1 | One-cycle halt request |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |

## Verification
The assertions check these rules on every cycle:
- Response pulses last one cycle, and halt and interrupt never coincide.
- Every halt or interrupt pulse comes with a trace pulse.
- Bits 15:14 read zero, and a write reads back and clears the status.
- A disabled unit never completes.
- A completed state holds.
- Two-level mode never skips from idle straight to level 2.

Only the bench scenarios show the match functions themselves. These are the address modes at the range edges, the size and lane qualification of data, the inversions, and the combined address and data condition. The scenarios also cover the exact order of status steps in two-level mode and the mapping of each response code to its output.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int LVL_W   = 14;
  localparam int N_LVL   = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LVL1 = 2'b01,
    ST_LVL2 = 2'b10
  } trig_status_e;

  typedef enum logic [1:0] {
    RSP_TRACE = 2'b00,
    RSP_HALT  = 2'b01,
    RSP_IRQ   = 2'b10,
    RSP_RSVD  = 2'b11
  } trig_resp_e;

  // per-level field layout, MSB first
  typedef struct packed {
    logic       en;
    logic       d_long;
    logic       d_lo_word;
    logic       d_up_word;
    logic [3:0] d_byte;     // [3] = offset 0 (data[31:24])
    logic       d_inv;
    logic       a_out_rng;
    logic       a_in_rng;
    logic       a_lo;
    logic       pc_en;
    logic       pc_inv;
  } lvl_cfg_t;
endpackage

// File: rtl/dbg_trig_level_match.sv
module dbg_trig_level_match
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  lvl_cfg_t            cfg_i,
  input  logic                acc_valid_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [1:0]          acc_size_i,
  input  logic [DATA_W-1:0]   acc_data_i,
  input  logic                pc_valid_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   brk_addr_lo_i,
  input  logic [ADDR_W-1:0]   brk_addr_hi_i,
  input  logic [DATA_W-1:0]   brk_data_i,
  input  logic [ADDR_W-1:0]   brk_pc_i,
  output logic                hit_o
);
  logic [LANES-1:0] lane_mask, lane_eq;
  logic             addr_en, data_en, in_rng, addr_match, data_match;
  logic             acc_hit, pc_hit;
  logic [1:0]       offs;

  assign offs = acc_addr_i[1:0];

  // lanes numbered from LSB: lane LANES-1 = data[31:24] = offset 0
  always_comb begin
    lane_mask = '0;
    unique case (acc_size_e'(acc_size_i))
      SZ_LONG: if (cfg_i.d_long) lane_mask = '1;
      SZ_WORD: begin
        if (!offs[1] && cfg_i.d_up_word) lane_mask = 4'b1100;
        if ( offs[1] && cfg_i.d_lo_word) lane_mask = 4'b0011;
      end
      SZ_BYTE: if (cfg_i.d_byte[2'd3 - offs]) lane_mask = 4'b1000 >> offs;
      default: lane_mask = '0;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = acc_data_i[8*l +: 8] == brk_data_i[8*l +: 8];
  end

  assign data_en    = cfg_i.d_long | cfg_i.d_lo_word | cfg_i.d_up_word | (|cfg_i.d_byte);
  assign data_match = (|lane_mask) & ((&(lane_eq | ~lane_mask)) ^ cfg_i.d_inv);

  assign addr_en    = cfg_i.a_lo | cfg_i.a_in_rng | cfg_i.a_out_rng;
  assign in_rng     = (acc_addr_i >= brk_addr_lo_i) && (acc_addr_i <= brk_addr_hi_i);
  assign addr_match = (cfg_i.a_lo      && acc_addr_i == brk_addr_lo_i) ||
                      (cfg_i.a_in_rng  && in_rng) ||
                      (cfg_i.a_out_rng && !in_rng);

  assign acc_hit = acc_valid_i && (addr_en || data_en) &&
                   (!addr_en || addr_match) && (!data_en || data_match);
  assign pc_hit  = pc_valid_i && cfg_i.pc_en && ((pc_i == brk_pc_i) ^ cfg_i.pc_inv);

  assign hit_o = cfg_i.en && (acc_hit || pc_hit);
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [N_LVL-1:0] en_i,
  input  logic [N_LVL-1:0] hit_i,
  input  trig_resp_e       resp_i,
  output trig_status_e     status_o,
  output logic             trig_o,
  output logic             halt_o,
  output logic             irq_o
);
  trig_status_e st_q, st_d;
  logic         fire;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    if (clear_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (en_i[0] && hit_i[0]) begin
            st_d = ST_LVL1;
            fire = !en_i[1];
          end else if (!en_i[0] && en_i[1] && hit_i[1]) begin
            st_d = ST_LVL2;
            fire = 1'b1;
          end
        end
        ST_LVL1: if (&en_i && hit_i[1]) begin
          st_d = ST_LVL2;
          fire = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      trig_o <= 1'b0;
      halt_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      trig_o <= fire;
      halt_o <= fire && resp_i == RSP_HALT;
      irq_o  <= fire && resp_i == RSP_IRQ;
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [31:0]       acc_data_i,
  input  logic              pc_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] brk_addr_lo_i,
  input  logic [ADDR_W-1:0] brk_addr_hi_i,
  input  logic [31:0]       brk_data_i,
  input  logic [ADDR_W-1:0] brk_pc_i,
  output logic [1:0]        status_o,
  output logic              trig_o,
  output logic              halt_o,
  output logic              dbg_irq_o
);
  logic [1:0]       resp_q;
  lvl_cfg_t         cfg_q [N_LVL];
  logic [N_LVL-1:0] hit, en;
  trig_status_e     status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q   <= '0;
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
    end else if (reg_we_i) begin
      resp_q   <= reg_wdata_i[31:30];
      cfg_q[1] <= reg_wdata_i[29:16];
      cfg_q[0] <= reg_wdata_i[13:0];
    end
  end

  assign reg_rdata_o = {resp_q, cfg_q[1], 2'b00, cfg_q[0]};

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign en[g] = cfg_q[g].en;
    dbg_trig_level_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg_i         (cfg_q[g]),
      .acc_valid_i   (acc_valid_i),
      .acc_addr_i    (acc_addr_i),
      .acc_size_i    (acc_size_i),
      .acc_data_i    (acc_data_i),
      .pc_valid_i    (pc_valid_i),
      .pc_i          (pc_i),
      .brk_addr_lo_i (brk_addr_lo_i),
      .brk_addr_hi_i (brk_addr_hi_i),
      .brk_data_i    (brk_data_i),
      .brk_pc_i      (brk_pc_i),
      .hit_o         (hit[g])
    );
  end

  dbg_trig_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (reg_we_i),
    .en_i     (en),
    .hit_i    (hit),
    .resp_i   (trig_resp_e'(resp_q)),
    .status_o (status),
    .trig_o   (trig_o),
    .halt_o   (halt_o),
    .irq_o    (dbg_irq_o)
  );

  assign status_o = status;
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic [1:0]  status_o,
  input logic        trig_o,
  input logic        halt_o,
  input logic        dbg_irq_o
);
  a_r2_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[15:14] == 2'b00);

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == ($past(reg_wdata_i) & 32'hFFFF_3FFF));

  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (status_o == 2'b00 && !trig_o));

  a_r4_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[29] && !reg_rdata_o[13] && !reg_we_i) |=> !trig_o);

  a_r10_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b00 && reg_rdata_o[29] && reg_rdata_o[13] && !reg_we_i)
      |=> status_o != 2'b10);

  a_r12_halt_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !halt_o);

  a_r12_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_irq_o |=> !dbg_irq_o);

  a_r12_resp_with_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o || dbg_irq_o) |-> (trig_o && !(halt_o && dbg_irq_o)));

  a_r12_trig_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status_o != 2'b00);

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b10 && !reg_we_i) |=> (status_o == 2'b10 && !trig_o));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .status_o    (status_o),
  .trig_o      (trig_o),
  .halt_o      (halt_o),
  .dbg_irq_o   (dbg_irq_o)
);

// File: tb/tb_dbg_trig_unit.sv
`timescale 1ns/1ps
module tb_dbg_trig_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_size_i = 2'd3;
  logic [31:0] acc_data_i = '0;
  logic        pc_valid_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] brk_addr_lo_i = 32'h0000_1000;
  logic [31:0] brk_addr_hi_i = 32'h0000_10FF;
  logic [31:0] brk_data_i = 32'h1122_3344;
  logic [31:0] brk_pc_i = 32'h0000_2000;
  logic [1:0]  status_o;
  logic        trig_o, halt_o, dbg_irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dbg_trig_unit #(.ADDR_W(32)) dut (.*);

  typedef struct packed {
    logic [31:0] cfg;
    logic        is_pc;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
    logic        exp;
  } vec_t;

  // single level-1, response halt; sizes 0 byte, 1 word, 2 long
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h4000_2004, 1'b0, 2'd2, 32'h0000_1000, 32'h0, 1'b1},        // R5 low
    '{32'h4000_2004, 1'b0, 2'd2, 32'h0000_1004, 32'h0, 1'b0},        // R5 low miss
    '{32'h4000_2008, 1'b0, 2'd2, 32'h0000_1080, 32'h0, 1'b1},        // R5 range
    '{32'h4000_2008, 1'b0, 2'd2, 32'h0000_10FF, 32'h0, 1'b1},        // R5 range edge
    '{32'h4000_2008, 1'b0, 2'd2, 32'h0000_1100, 32'h0, 1'b0},        // R5 out
    '{32'h4000_2010, 1'b0, 2'd2, 32'h0000_0FFC, 32'h0, 1'b1},        // R5 inv range
    '{32'h4000_2010, 1'b0, 2'd2, 32'h0000_1010, 32'h0, 1'b0},        // R5 inv in
    '{32'h4000_3000, 1'b0, 2'd2, 32'h0000_5000, 32'h1122_3344, 1'b1},// R6 long
    '{32'h4000_3000, 1'b0, 2'd1, 32'h0000_5000, 32'h1122_3344, 1'b0},// R6 size miss
    '{32'h4000_2400, 1'b0, 2'd1, 32'h0000_5000, 32'h1122_FFFF, 1'b1},// R6 upper word
    '{32'h4000_2400, 1'b0, 2'd1, 32'h0000_5002, 32'h1122_FFFF, 1'b0},// R6 wrong half
    '{32'h4000_2800, 1'b0, 2'd1, 32'h0000_5002, 32'hAAAA_3344, 1'b1},// R6 lower word
    '{32'h4000_2100, 1'b0, 2'd0, 32'h0000_5001, 32'h0022_0000, 1'b1},// R6 byte off1
    '{32'h4000_2100, 1'b0, 2'd0, 32'h0000_5001, 32'h0023_0000, 1'b0},// R6 byte miss
    '{32'h4000_2040, 1'b0, 2'd0, 32'h0000_5003, 32'h0000_0044, 1'b1},// R6 byte off3
    '{32'h4000_2060, 1'b0, 2'd0, 32'h0000_5003, 32'h0000_0045, 1'b1},// R7 invert
    '{32'h4000_2060, 1'b0, 2'd0, 32'h0000_5003, 32'h0000_0044, 1'b0},// R7 invert eq
    '{32'h4000_3004, 1'b0, 2'd2, 32'h0000_1000, 32'h1122_3344, 1'b1},// R9 both
    '{32'h4000_3004, 1'b0, 2'd2, 32'h0000_1004, 32'h1122_3344, 1'b0},// R9 addr miss
    '{32'h4000_2002, 1'b1, 2'd3, 32'h0000_2000, 32'h0, 1'b1},        // R8 pc
    '{32'h4000_2002, 1'b1, 2'd3, 32'h0000_2004, 32'h0, 1'b0},        // R8 pc miss
    '{32'h4000_2003, 1'b1, 2'd3, 32'h0000_2004, 32'h0, 1'b1},        // R8 pc inv
    '{32'h4000_2000, 1'b0, 2'd2, 32'h0000_1000, 32'h0, 1'b0},        // R5 R6 none
    '{32'h4000_0004, 1'b0, 2'd2, 32'h0000_1000, 32'h0, 1'b0}         // R4 disabled
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // one-cycle stimulus, outputs observed one edge later
  task automatic drive(input logic is_pc, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d);
    acc_valid_i = !is_pc; pc_valid_i = is_pc;
    acc_size_i = sz; acc_addr_i = a; acc_data_i = d; pc_i = a;
    @(negedge clk_i);
    acc_valid_i = 1'b0; pc_valid_i = 1'b0;
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 rdata", reg_rdata_o, 32'h0);
    chk("R1 outputs", {28'h0, status_o, trig_o, halt_o | dbg_irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr(32'hFFFF_FFFF);
    chk("R2 readback", reg_rdata_o, 32'hFFFF_3FFF);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].cfg);
      drive(VECS[i].is_pc, VECS[i].size, VECS[i].addr, VECS[i].data);
      chk($sformatf("R11 vec%0d trig", i), {31'h0, trig_o}, {31'h0, VECS[i].exp});
      chk($sformatf("R12 vec%0d halt", i), {31'h0, halt_o}, {31'h0, VECS[i].exp});
      chk($sformatf("R11 vec%0d status", i), {30'h0, status_o}, {31'h0, VECS[i].exp});
    end

    // R13: completed state holds, no second pulse
    wr(32'h4000_2004);
    drive(1'b0, 2'd2, 32'h1000, 32'h0);
    drive(1'b0, 2'd2, 32'h1000, 32'h0);
    chk("R13 no repeat", {30'h0, status_o, trig_o}, 32'h2);
    // R3: write clears status, no pulse
    wr(32'h4000_2004);
    chk("R3 cleared", {30'h0, status_o, trig_o}, 32'h0);

    // R10: two-level, irq response, L2 = pc, L1 = low addr
    wr(32'hA002_2004);
    drive(1'b1, 2'd3, 32'h2000, 32'h0);
    chk("R10 l2 early ignored", {30'h0, status_o, trig_o}, 32'h0);
    drive(1'b0, 2'd2, 32'h1000, 32'h0);
    chk("R10 l1 hit", {28'h0, status_o, trig_o, dbg_irq_o}, 32'h4);
    drive(1'b1, 2'd3, 32'h2000, 32'h0);
    chk("R10 l2 hit", {28'h0, status_o, trig_o, dbg_irq_o}, 32'hB);
    chk("R12 irq no halt", {31'h0, halt_o}, 32'h0);
    @(negedge clk_i);
    chk("R12 irq pulse ends", {30'h0, trig_o, dbg_irq_o}, 32'h0);

    // R11: level-2 only, trace-only response
    wr(32'h2002_0000);
    drive(1'b1, 2'd3, 32'h2000, 32'h0);
    chk("R11 l2 only", {27'h0, status_o, trig_o, halt_o, dbg_irq_o}, 32'h14);

    // R12: reserved code behaves as trace-only
    wr(32'hC000_2004);
    drive(1'b0, 2'd2, 32'h1000, 32'h0);
    chk("R12 reserved", {27'h0, status_o, trig_o, halt_o, dbg_irq_o}, 32'h0C);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset again", {reg_rdata_o[31:2], status_o}, 32'h0);
    finish_sim();
  end
endmodule